// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block turns a 10-bit unsigned sample into the on/off pattern for the current switches of a segmented current-steering converter. The five high-order bits become a thermometer code over 31 equal-weight major segments, each worth 32 LSB. The five low-order bits drive five binary-weighted switches of 1, 2, 4, 8 and 16 LSB. A second vector, the bitwise inverse of the first, steers the complementary output leg.

The path has two register stages. The first stage captures the sample on the rising clock edge. The second stage holds the decoded 36-line pattern, so every switch line changes on the same edge. A sample therefore reaches the switches two edges after it is presented. A sleep input parks both switch vectors at zero and freezes the captured sample. A synchronous reset clears both stages.

Top module: `seg_dac_decoder`

## Requirements
- R1: A sample on `code_i` is captured on a rising edge of `clk`, and its decoded pattern appears on the outputs after exactly the second rising edge. After only one edge, the outputs still show the previous sample.
- R2: Segment line k (0..30) sits at bit 5+k of `sw_main_o` and is 1 exactly when k < `code[9:5]`. The segment field therefore fills from bit 5 upward as a thermometer code.
- R3: Bits [4:0] of `sw_main_o` equal `code[4:0]`. Bit i carries weight 2^i LSB.
- R4: For all 1024 codes, 32 times the number of asserted segment lines plus the binary value of bits [4:0] equals the code.
- R5: When the code steps from a value with `code[4:0]` = 31 to the next value, the five binary lines all turn off and exactly one more segment line turns on.
- R6: Code 0 gives `sw_main_o` = all zeros. Code 1023 gives all 36 lines set.
- R7: Outside sleep and reset, `sw_comp_o` is the bitwise inverse of `sw_main_o`.
- R8: At each rising edge with `sleep_i` high (and reset low), both `sw_main_o` and `sw_comp_o` become all zeros.
- R9: While `sleep_i` is high, the captured sample is held and `code_i` is ignored. On the first edge after `sleep_i` falls, the outputs show the sample held from before sleep. A new input appears one edge later.
- R10: A rising edge with `rst` high clears both stages. `sw_main_o` becomes all zeros and `sw_comp_o` all ones. The first pattern after reset decodes code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | Power-down request, active high |
| code_i | input | 10 | Unsigned sample, bit 9 most significant |
| sw_main_o | output | 36 | Primary switch vector: [35:5] segments, [4:0] binary lines |
| sw_comp_o | output | 36 | Complementary switch vector |

## Verification
The assertions assume that `rst` and `sleep_i` change only between clock edges. They also assume that each check refers to a cycle whose preceding edge was outside reset; a flag in the checker, set one edge after reset ends, guards every check that looks back. The bench drives all inputs on the falling edge and holds reset for several cycles before any check. Sleep is raised and lowered around a known sample, and the held code is observed on the outputs, so every relation is exercised from a defined state.

// File: rtl/dacdec_pkg.sv
`timescale 1ns/1ps
package dacdec_pkg;

  // Action of the output stage at the next edge
  typedef enum logic [1:0] {
    OUT_CLEAR = 2'd0,
    OUT_PARK  = 2'd1,
    OUT_RUN   = 2'd2
  } out_mode_e;

  // Segment line k is on when the upper field exceeds k
  function automatic logic thermo_line(input int unsigned k, input int unsigned upper);
    return (k < upper);
  endfunction

  // Number of segment lines for a given upper field width
  function automatic int unsigned seg_lines(input int unsigned seg_bits);
    return (1 << seg_bits) - 1;
  endfunction

  // Select the output stage action; reset has priority over sleep
  function automatic out_mode_e pick_mode(input logic rst, input logic sleep);
    if (rst)        return OUT_CLEAR;
    else if (sleep) return OUT_PARK;
    else            return OUT_RUN;
  endfunction

endpackage

// File: rtl/dacdec_capture.sv
`timescale 1ns/1ps
module dacdec_capture #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);

  always_ff @(posedge clk) begin
    if (rst)
      code_o <= '0;
    else if (!hold_i)
      code_o <= code_i;
  end

endmodule

// File: rtl/dacdec_thermo.sv
`timescale 1ns/1ps
module dacdec_thermo #(
  parameter int IN_W  = 5,
  parameter int LINES = 31
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [LINES-1:0] therm_o
);
  import dacdec_pkg::*;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign therm_o[k] = thermo_line(k, int'(val_i));
  end

endmodule

// File: rtl/dacdec_outreg.sv
`timescale 1ns/1ps
module dacdec_outreg #(
  parameter int SW_W = 36
) (
  input  logic                  clk,
  input  dacdec_pkg::out_mode_e mode_i,
  input  logic [SW_W-1:0]       pat_i,
  output logic [SW_W-1:0]       main_o,
  output logic [SW_W-1:0]       comp_o
);
  import dacdec_pkg::*;

  always_ff @(posedge clk) begin
    case (mode_i)
      OUT_RUN: begin
        main_o <= pat_i;
        comp_o <= ~pat_i;
      end
      OUT_PARK: begin
        main_o <= '0;
        comp_o <= '0;
      end
      default: begin
        main_o <= '0;
        comp_o <= '1;
      end
    endcase
  end

endmodule

// File: rtl/seg_dac_decoder.sv
`timescale 1ns/1ps
module seg_dac_decoder #(
  parameter int SEG_BITS = 5,
  parameter int BIN_BITS = 5
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   sleep_i,
  input  logic [SEG_BITS+BIN_BITS-1:0]           code_i,
  output logic [(2**SEG_BITS)-1+BIN_BITS-1:0]    sw_main_o,
  output logic [(2**SEG_BITS)-1+BIN_BITS-1:0]    sw_comp_o
);
  import dacdec_pkg::*;

  localparam int CODE_W    = SEG_BITS + BIN_BITS;
  localparam int SEG_LINES = (2**SEG_BITS) - 1;
  localparam int SW_W      = SEG_LINES + BIN_BITS;

  // Named internal events, visible to the bound checker
  logic [CODE_W-1:0]    code_q;
  logic [SEG_LINES-1:0] seg_lines_w;
  logic [BIN_BITS-1:0]  bin_lines_w;
  logic [SW_W-1:0]      sw_next;
  out_mode_e            stage_mode;

  dacdec_capture #(.CODE_W(CODE_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .hold_i (sleep_i),
    .code_i (code_i),
    .code_o (code_q)
  );

  dacdec_thermo #(.IN_W(SEG_BITS), .LINES(SEG_LINES)) u_therm (
    .val_i   (code_q[CODE_W-1:BIN_BITS]),
    .therm_o (seg_lines_w)
  );

  assign bin_lines_w = code_q[BIN_BITS-1:0];
  assign sw_next     = {seg_lines_w, bin_lines_w};
  assign stage_mode  = pick_mode(rst, sleep_i);

  dacdec_outreg #(.SW_W(SW_W)) u_out (
    .clk    (clk),
    .mode_i (stage_mode),
    .pat_i  (sw_next),
    .main_o (sw_main_o),
    .comp_o (sw_comp_o)
  );

endmodule

// File: rtl/dacdec_chk.sv
`timescale 1ns/1ps
module dacdec_chk #(
  parameter int SEG_BITS = 5,
  parameter int BIN_BITS = 5
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                sleep_i,
  input logic [SEG_BITS+BIN_BITS-1:0]        code_q,
  input logic [(2**SEG_BITS)-1+BIN_BITS-1:0] main_o,
  input logic [(2**SEG_BITS)-1+BIN_BITS-1:0] comp_o
);
  localparam int CODE_W    = SEG_BITS + BIN_BITS;
  localparam int SEG_LINES = (2**SEG_BITS) - 1;
  localparam int SW_W      = SEG_LINES + BIN_BITS;

  logic              primed;
  logic              sleep_d;
  logic [CODE_W-1:0] code_d;
  logic [SEG_LINES-1:0] seg_f;

  assign seg_f = main_o[SW_W-1:BIN_BITS];

  always_ff @(posedge clk) begin
    primed  <= !rst;
    sleep_d <= sleep_i;
    code_d  <= code_q;
  end

  // R2
  thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> (((seg_f >> 1) & ~seg_f) == '0));

  // R4
  weight_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && !sleep_d) |->
      (($countones(seg_f) << BIN_BITS) + int'(main_o[BIN_BITS-1:0]) == int'(code_d)));

  // R7
  comp_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && !sleep_d) |-> (comp_o == ~main_o));

  // R8
  sleep_park_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && sleep_d) |-> (main_o == '0 && comp_o == '0));

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && sleep_d) |-> $stable(code_q));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (main_o == '0 && comp_o == '1 && code_q == '0));

endmodule

bind seg_dac_decoder dacdec_chk #(.SEG_BITS(SEG_BITS), .BIN_BITS(BIN_BITS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sleep_i (sleep_i),
  .code_q  (code_q),
  .main_o  (sw_main_o),
  .comp_o  (sw_comp_o)
);

// File: tb/tb_seg_dac_decoder.sv
`timescale 1ns/1ps
module tb_seg_dac_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep_i = 1'b0;
  logic [9:0]  code_i = '0;
  logic [35:0] sw_main_o, sw_comp_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_dac_decoder dut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .code_i(code_i),
    .sw_main_o(sw_main_o), .sw_comp_o(sw_comp_o)
  );

  // {code, expected segment count, expected binary field}
  localparam logic [19:0] VEC_TAB [0:7] = '{
    {10'd0,    5'd0,  5'd0},
    {10'd1,    5'd0,  5'd1},
    {10'd31,   5'd0,  5'd31},
    {10'd32,   5'd1,  5'd0},
    {10'd33,   5'd1,  5'd1},
    {10'd512,  5'd16, 5'd0},
    {10'd1022, 5'd31, 5'd30},
    {10'd1023, 5'd31, 5'd31}
  };

  // Expected switch vector from a segment count and a binary field
  function automatic logic [35:0] exp_vec(input int nseg, input int bin);
    logic [35:0] v = '0;
    for (int i = 0; i < nseg; i++) v[5+i] = 1'b1;
    v[4:0] = bin[4:0];
    return v;
  endfunction

  function automatic logic [35:0] exp_code(input int c);
    return exp_vec(c / 32, c % 32);
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive on a falling edge, then wait past two rising edges
  task automatic put(input int c);
    @(negedge clk) code_i = c[9:0];
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : main_seq
    int pcnt, pbin;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset main", sw_main_o, '0);
    chk("R10 reset comp", sw_comp_o, '1);
    rst = 1'b0;

    // Table walk: R2 R3 R6 R7
    for (int i = 0; i < 8; i++) begin
      put(int'(VEC_TAB[i][19:10]));
      chk("R2/R3 table main", sw_main_o,
          exp_vec(int'(VEC_TAB[i][9:5]), int'(VEC_TAB[i][4:0])));
      chk("R7 table comp", sw_comp_o,
          ~exp_vec(int'(VEC_TAB[i][9:5]), int'(VEC_TAB[i][4:0])));
    end

    // R6: end points
    put(0);
    chk("R6 code 0", sw_main_o, 36'h0);
    put(1023);
    chk("R6 code 1023", sw_main_o, {36{1'b1}});

    // R4: all codes, weighted sum
    for (int c = 0; c < 1024; c++) begin
      put(c);
      chk_int("R4 weighted sum", $countones(sw_main_o[35:5]) * 32 + int'(sw_main_o[4:0]), c);
      chk("R2 sweep vector", sw_main_o, exp_code(c));
    end

    // R5: carry into next segment
    for (int s = 0; s < 31; s += 10) begin
      put(s * 32 + 31);
      pcnt = $countones(sw_main_o[35:5]);
      pbin = int'(sw_main_o[4:0]);
      put(s * 32 + 32);
      chk_int("R5 binary off before", pbin, 31);
      chk_int("R5 binary off after", int'(sw_main_o[4:0]), 0);
      chk_int("R5 one more segment", $countones(sw_main_o[35:5]), pcnt + 1);
    end

    // R1: latency of exactly two edges
    put(100);
    @(negedge clk) code_i = 10'd200;
    @(negedge clk);
    chk("R1 one edge keeps old", sw_main_o, exp_code(100));
    @(negedge clk);
    chk("R1 two edges show new", sw_main_o, exp_code(200));

    // R8, R9: sleep parks and holds
    put(777);
    @(negedge clk) begin sleep_i = 1'b1; code_i = 10'd5; end
    @(negedge clk);
    chk("R8 sleep main zero", sw_main_o, '0);
    chk("R8 sleep comp zero", sw_comp_o, '0);
    @(negedge clk) code_i = 10'd9;
    @(negedge clk);
    chk("R8 sleep still zero", sw_main_o, '0);
    @(negedge clk) begin sleep_i = 1'b0; code_i = 10'd300; end
    @(negedge clk);
    chk("R9 resume held code", sw_main_o, exp_code(777));
    chk("R7 resume comp", sw_comp_o, ~exp_code(777));
    @(negedge clk);
    chk("R9 new code next edge", sw_main_o, exp_code(300));

    // R10: mid-run reset clears the capture stage too
    put(600);
    @(negedge clk) begin rst = 1'b1; code_i = 10'd450; end
    @(negedge clk);
    chk("R10 reset main", sw_main_o, '0);
    chk("R10 reset comp", sw_comp_o, '1);
    @(negedge clk) begin rst = 1'b0; code_i = 10'd451; end
    @(negedge clk);
    chk("R10 first pattern decodes 0", sw_main_o, '0);
    @(negedge clk);
    chk("R10 then new code", sw_main_o, exp_code(451));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule